// File: doc/BRIEF.md
# Microcoded Stack Add Sequencer

This block holds an operand stack in a small two-port register memory and executes one integer add operation on it. The add does not happen in a single step. A controller walks a fixed chain of one-cycle micro-operations over a datapath of registers. The datapath has a stack pointer with a plus/minus one adjuster, a data-in register, a data-out register, two operand registers, an ALU input latch and an ALU result register. Each register carries a valid flag, and a micro-operation may fire only when the flags it depends on are in the required state.

The stack pointer equals the number of live entries, and the top entry sits at that index, so entries occupy indices 1 to DEPTH. Index 0 is never written. A test port lets the surrounding logic push a word onto the stack and read any entry combinationally. Software-visible status is limited to busy, a one-cycle done pulse, a one-cycle underflow pulse and the current stack pointer.

Top module: `stk_add_seq`

## Requirements
- R1: While reset (active-low, synchronous) is applied, the stack pointer reads 0 and busy, done and underflow read 0.
- R2: A push strobe while idle, with no start strobe and the stack not full, writes the data word at index sp+1 and raises the stack pointer by one at the same clock edge.
- R3: A push strobe while the stack pointer equals DEPTH changes neither the stack pointer nor any entry.
- R4: A start strobe with opcode 8'h60, accepted while idle with at least two entries, raises busy for exactly 10 cycles; done is high for exactly one cycle, in the first cycle with busy low again.
- R5: When the add completes, the entry at the old index sp-1 holds the unsigned 32-bit sum (mod 2^32) of the old entries at sp and sp-1, and the entries below it are unchanged.
- R6: A start strobe with opcode 8'h60 while idle and with fewer than two entries leaves busy low and the stack pointer unchanged, and pulses underflow for exactly one cycle.
- R7: A start strobe with any opcode other than 8'h60 is ignored: no busy, no underflow, no stack pointer change.
- R8: While busy, start and push strobes are ignored.
- R9: During an add the stack pointer steps by one at a time: it is old-1 after the first micro-operation, old-2 after the fourth, and back to old-1 after the ninth, where it stays.
- R10: When start and push strobes arrive in the same idle cycle, the start is taken and the push is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe for an operation |
| opcode_i | input | 8 | Operation code sampled with start_i; 8'h60 is add |
| push_i | input | 1 | Test push strobe |
| push_data_i | input | DATA_W | Word to push |
| peek_idx_i | input | AW | Stack index to read |
| peek_data_o | output | DATA_W | Combinational read of the entry at peek_idx_i |
| busy_o | output | 1 | Micro-operation sequence in progress |
| done_o | output | 1 | One-cycle pulse after the final write |
| underflow_o | output | 1 | One-cycle pulse when an add is refused |
| sp_o | output | AW | Stack pointer (number of live entries) |

## Verification
A wrong micro-operation order or a stuck valid flag stalls the chain or shifts its length. Both show on the ports within about ten cycles, as a busy window that is not exactly ten cycles long or as a done pulse in the wrong cycle. A fault in the pointer adjuster shows in the stack pointer values sampled after the first, fourth and ninth steps. It also shows as a sum at the wrong index when entries are read back right after done. A corrupted operand or result register shows as a wrong sum on the first readback. The stimulus uses carry-out and all-ones values so that truncation faults are exposed.

// File: rtl/stk_add_pkg.sv
// Shared constants and the micro-operation encoding for the stack add sequencer.
package stk_add_pkg;
    localparam logic [7:0] OP_IADD    = 8'h60;
    localparam int         SEQ_CYCLES = 10;

    typedef enum logic [3:0] {
        UOP_IDLE,
        UOP_ADDR_A,
        UOP_READ_A,
        UOP_MOVE_A,
        UOP_ADDR_B,
        UOP_READ_B,
        UOP_MOVE_B,
        UOP_DUAL_LD,
        UOP_ADD,
        UOP_LOAD_OUT,
        UOP_WRITE
    } uop_e;
endpackage

// File: rtl/stk_mem.sv
// Stack storage: DEPTH+1 words, one synchronous write port and two
// combinational read ports. Index 0 exists but is never a live entry.
// Assumes addresses beyond the last entry read as zero and never write.
module stk_mem #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int AW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    localparam int ENTRIES = DEPTH + 1;

    logic [DATA_W-1:0] mem [ENTRIES];

    // Clear on reset, otherwise write the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) mem[e] <= '0;
        end else if (we && (int'(waddr) < ENTRIES)) begin
            mem[waddr] <= wdata;
        end
    end

    // Datapath read port.
    always_comb rdata_a = (int'(raddr_a) < ENTRIES) ? mem[raddr_a] : '0;

    // Test read port.
    always_comb rdata_b = (int'(raddr_b) < ENTRIES) ? mem[raddr_b] : '0;
endmodule

// File: rtl/stk_ptr.sv
// Stack pointer with a plus/minus one adjuster. Holds the live entry count.
// Assumes inc and dec are never requested together by the controller;
// if they are, the pointer holds.
module stk_ptr #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [AW-1:0] sp,
    output logic [AW-1:0] sp_next_up,
    output logic          has_two,
    output logic          full
);
    logic [AW-1:0] sp_q;

    // Apply one step per cycle at most.
    always_ff @(posedge clk) begin
        if (!rst_n)          sp_q <= '0;
        else if (inc && !dec) sp_q <= sp_q + AW'(1);
        else if (dec && !inc) sp_q <= sp_q - AW'(1);
    end

    // Derived views of the pointer for the controller and write address.
    always_comb begin
        sp         = sp_q;
        sp_next_up = sp_q + AW'(1);
        has_two    = (int'(sp_q) >= 2);
        full       = (int'(sp_q) == DEPTH);
    end
endmodule

// File: rtl/stk_add_dp.sv
// Add datapath: address, data-in, operand, ALU and data-out registers,
// each with a valid flag. Reports whether the guard of the micro-operation
// presented on uop holds, and performs it when fire is high.
// Assumes the controller only raises fire when guard_ok is high.
module stk_add_dp
    import stk_add_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  uop_e              uop,
    input  logic              fire,
    input  logic [AW-1:0]     sp,
    input  logic [DATA_W-1:0] rdata,
    output logic [AW-1:0]     addr,
    output logic [DATA_W-1:0] dout,
    output logic              guard_ok
);
    logic [AW-1:0]     addr_q;
    logic [DATA_W-1:0] din_q, rega_q, regb_q, alu_a_q, alu_b_q, alu_out_q, dout_q;
    logic              din_v, rega_v, regb_v, alu_in_v, alu_out_v, dout_v;

    // Guard of each micro-operation, taken from the valid flags only.
    always_comb begin
        unique case (uop)
            UOP_ADDR_A, UOP_ADDR_B, UOP_READ_A, UOP_READ_B: guard_ok = !din_v;
            UOP_MOVE_A:   guard_ok = din_v && !rega_v;
            UOP_MOVE_B:   guard_ok = din_v && !regb_v;
            UOP_DUAL_LD:  guard_ok = rega_v && regb_v && !alu_in_v;
            UOP_ADD:      guard_ok = alu_in_v && !alu_out_v;
            UOP_LOAD_OUT: guard_ok = alu_out_v && !dout_v;
            UOP_WRITE:    guard_ok = dout_v;
            default:      guard_ok = 1'b0;
        endcase
    end

    // Datapath registers: each micro-operation touches its own slice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            din_q     <= '0;
            rega_q    <= '0;
            regb_q    <= '0;
            alu_a_q   <= '0;
            alu_b_q   <= '0;
            alu_out_q <= '0;
            dout_q    <= '0;
        end else if (fire) begin
            unique case (uop)
                UOP_ADDR_A, UOP_ADDR_B: addr_q <= sp;
                UOP_READ_A, UOP_READ_B: din_q  <= rdata;
                UOP_MOVE_A:   rega_q <= din_q;
                UOP_MOVE_B:   regb_q <= din_q;
                UOP_DUAL_LD: begin
                    alu_a_q <= rega_q;
                    alu_b_q <= regb_q;
                end
                UOP_ADD:      alu_out_q <= alu_a_q + alu_b_q;
                UOP_LOAD_OUT: dout_q    <= alu_out_q;
                default: ;
            endcase
        end
    end

    // Valid flags: set by the producing step, cleared by the consumer or write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_v     <= 1'b0;
            rega_v    <= 1'b0;
            regb_v    <= 1'b0;
            alu_in_v  <= 1'b0;
            alu_out_v <= 1'b0;
            dout_v    <= 1'b0;
        end else if (fire) begin
            unique case (uop)
                UOP_READ_A, UOP_READ_B: din_v <= 1'b1;
                UOP_MOVE_A: begin
                    rega_v <= 1'b1;
                    din_v  <= 1'b0;
                end
                UOP_MOVE_B: begin
                    regb_v <= 1'b1;
                    din_v  <= 1'b0;
                end
                UOP_DUAL_LD:  alu_in_v  <= 1'b1;
                UOP_ADD:      alu_out_v <= 1'b1;
                UOP_LOAD_OUT: dout_v    <= 1'b1;
                UOP_WRITE: begin
                    dout_v    <= 1'b0;
                    rega_v    <= 1'b0;
                    regb_v    <= 1'b0;
                    alu_in_v  <= 1'b0;
                    alu_out_v <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // Outputs towards memory.
    always_comb begin
        addr = addr_q;
        dout = dout_q;
    end
endmodule

// File: rtl/stk_add_ctrl.sv
// Micro-operation sequencer. Idle until an add start is accepted, then
// steps through the ten micro-operations, one per cycle while the guard
// reported by the datapath holds. Also arbitrates test pushes.
// Assumes has_two and full reflect the pointer in the current cycle.
module stk_add_ctrl
    import stk_add_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] opcode_i,
    input  logic       push_i,
    input  logic       has_two,
    input  logic       full,
    input  logic       guard_ok,
    output uop_e       uop,
    output logic       fire,
    output logic       push_acc,
    output logic       busy,
    output logic       done,
    output logic       underflow
);
    uop_e state_q, state_d;
    logic add_req, done_q, uflow_q;

    // Request decode and step enable.
    always_comb begin
        add_req  = (state_q == UOP_IDLE) && start_i && (opcode_i == OP_IADD);
        fire     = (state_q != UOP_IDLE) && guard_ok;
        push_acc = (state_q == UOP_IDLE) && push_i && !start_i && !full;
    end

    // Next micro-operation.
    always_comb begin
        state_d = state_q;
        if (state_q == UOP_IDLE) begin
            if (add_req && has_two) state_d = UOP_ADDR_A;
        end else if (fire) begin
            unique case (state_q)
                UOP_ADDR_A:   state_d = UOP_READ_A;
                UOP_READ_A:   state_d = UOP_MOVE_A;
                UOP_MOVE_A:   state_d = UOP_ADDR_B;
                UOP_ADDR_B:   state_d = UOP_READ_B;
                UOP_READ_B:   state_d = UOP_MOVE_B;
                UOP_MOVE_B:   state_d = UOP_DUAL_LD;
                UOP_DUAL_LD:  state_d = UOP_ADD;
                UOP_ADD:      state_d = UOP_LOAD_OUT;
                UOP_LOAD_OUT: state_d = UOP_WRITE;
                default:      state_d = UOP_IDLE;
            endcase
        end
    end

    // State and pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= UOP_IDLE;
            done_q  <= 1'b0;
            uflow_q <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= fire && (state_q == UOP_WRITE);
            uflow_q <= add_req && !has_two;
        end
    end

    // Status outputs.
    always_comb begin
        uop       = state_q;
        busy      = (state_q != UOP_IDLE);
        done      = done_q;
        underflow = uflow_q;
    end
endmodule

// File: rtl/stk_add_seq.sv
// Top level: stack memory, pointer, add datapath and sequencer.
// Assumes DEPTH >= 2 and DATA_W >= 1.
module stk_add_seq
    import stk_add_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [7:0]        opcode_i,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic [AW-1:0]     peek_idx_i,
    output logic [DATA_W-1:0] peek_data_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              underflow_o,
    output logic [AW-1:0]     sp_o
);
    uop_e              uop;
    logic              fire, push_acc, guard_ok, has_two, full;
    logic              sp_inc, sp_dec, mem_we;
    logic [AW-1:0]     sp, sp_up, dp_addr, mem_waddr;
    logic [DATA_W-1:0] dp_dout, mem_wdata, mem_rdata;

    // Pointer steps and memory write selection.
    always_comb begin
        sp_dec    = fire && ((uop == UOP_ADDR_A) || (uop == UOP_ADDR_B));
        sp_inc    = push_acc || (fire && (uop == UOP_LOAD_OUT));
        mem_we    = push_acc || (fire && (uop == UOP_WRITE));
        mem_waddr = push_acc ? sp_up : sp;
        mem_wdata = push_acc ? push_data_i : dp_dout;
    end

    stk_ptr #(.DEPTH(DEPTH), .AW(AW)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc        (sp_inc),
        .dec        (sp_dec),
        .sp         (sp),
        .sp_next_up (sp_up),
        .has_two    (has_two),
        .full       (full)
    );

    stk_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (mem_we),
        .waddr   (mem_waddr),
        .wdata   (mem_wdata),
        .raddr_a (dp_addr),
        .rdata_a (mem_rdata),
        .raddr_b (peek_idx_i),
        .rdata_b (peek_data_o)
    );

    stk_add_dp #(.DATA_W(DATA_W), .AW(AW)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .uop      (uop),
        .fire     (fire),
        .sp       (sp),
        .rdata    (mem_rdata),
        .addr     (dp_addr),
        .dout     (dp_dout),
        .guard_ok (guard_ok)
    );

    stk_add_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .opcode_i  (opcode_i),
        .push_i    (push_i),
        .has_two   (has_two),
        .full      (full),
        .guard_ok  (guard_ok),
        .uop       (uop),
        .fire      (fire),
        .push_acc  (push_acc),
        .busy      (busy_o),
        .done      (done_o),
        .underflow (underflow_o)
    );

    // Pointer to the port.
    always_comb sp_o = sp;
endmodule

// File: rtl/stk_add_seq_chk.sv
// Port-level checker for the stack add sequencer, bound to the top module.
// Measures the busy window with a counter instead of a long $past.
module stk_add_seq_chk
    import stk_add_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy_o,
    input logic          done_o,
    input logic          underflow_o,
    input logic [AW-1:0] sp_o
);
    logic [7:0] busy_run;

    // Count consecutive busy cycles; value is held into the done cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_run <= '0;
        else if (busy_o) busy_run <= busy_run + 8'd1;
        else             busy_run <= '0;
    end

    assert_sp_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(sp_o) <= DEPTH);

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (int'(busy_run) == SEQ_CYCLES));

    assert_busy_end_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    assert_underflow_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |=> !underflow_o);

    assert_underflow_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |-> (!busy_o && int'(sp_o) < 2));

    assert_sp_unit_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ((sp_o == $past(sp_o)) || (sp_o == $past(sp_o) + AW'(1))
                    || (sp_o == $past(sp_o) - AW'(1))));
endmodule

bind stk_add_seq stk_add_seq_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .underflow_o (underflow_o),
    .sp_o        (sp_o)
);

// File: tb/stk_add_seq_tb_top.sv
// Self-checking bench: a vector table of add operands, then directed tests.
module stk_add_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 32;
    localparam int DEPTH      = 16;
    localparam int AW         = $clog2(DEPTH + 1);
    localparam logic [7:0] OP_ADD = 8'h60;
    localparam int NVEC = 6;
    // {first pushed, second pushed, expected sum}
    localparam logic [95:0] VEC [NVEC] = '{
        {32'h0000_0003, 32'h0000_0004, 32'h0000_0007},
        {32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000},
        {32'h8000_0000, 32'h8000_0000, 32'h0000_0000},
        {32'h1234_5678, 32'h0EDC_BA98, 32'h2111_1110},
        {32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
        {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [7:0]        opcode_i = '0;
    logic              push_i = 1'b0;
    logic [DATA_W-1:0] push_data_i = '0;
    logic [AW-1:0]     peek_idx_i = '0;
    logic [DATA_W-1:0] peek_data_o;
    logic              busy_o, done_o, underflow_o;
    logic [AW-1:0]     sp_o;

    int checks = 0;
    int fails  = 0;
    logic [DATA_W-1:0] mdl [DEPTH+1];
    int msp = 0;

    stk_add_seq #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
        .push_i(push_i), .push_data_i(push_data_i), .peek_idx_i(peek_idx_i),
        .peek_data_o(peek_data_o), .busy_o(busy_o), .done_o(done_o),
        .underflow_o(underflow_o), .sp_o(sp_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic peek_chk(input string req, input int idx, input logic [31:0] exp);
        peek_idx_i = AW'(idx);
        #1;
        chk(req, peek_data_o, exp);
    endtask

    // Push one word at a negedge; model follows the rules of R2/R3.
    task automatic do_push(input logic [31:0] d);
        push_i = 1'b1;
        push_data_i = d;
        @(negedge clk);
        push_i = 1'b0;
        if (msp < DEPTH) begin
            msp++;
            mdl[msp] = d;
        end
        chk("R2 push sp", 32'(sp_o), 32'(msp));
    endtask

    // Run one add; poke=1 drives start and push in the middle (R8).
    task automatic run_add(input bit poke, input bit push_same);
        int s0 = msp;
        logic [31:0] sum = mdl[s0] + mdl[s0-1];
        start_i = 1'b1;
        opcode_i = OP_ADD;
        push_i = push_same;
        push_data_i = 32'hBAD0_0001;
        @(negedge clk);
        start_i = 1'b0;
        push_i = 1'b0;
        for (int n = 1; n <= 11; n++) begin
            if (n > 1) @(negedge clk);
            if (poke && n == 3) begin
                start_i = 1'b1; push_i = 1'b1; push_data_i = 32'hBAD0_0002;
            end
            if (poke && n == 5) begin
                start_i = 1'b0; push_i = 1'b0;
            end
            chk("R4 busy window", 32'(busy_o), 32'(n <= 10));
            chk("R4 done pulse", 32'(done_o), 32'(n == 11));
            if (n == 2)  chk("R9 sp after first step", 32'(sp_o), 32'(s0 - 1));
            if (n == 5)  chk("R9 sp after fourth step", 32'(sp_o), 32'(s0 - 2));
            if (n == 10) chk("R9 sp after ninth step", 32'(sp_o), 32'(s0 - 1));
        end
        msp = s0 - 1;
        mdl[msp] = sum;
        chk("R5 sp after add", 32'(sp_o), 32'(msp));
        peek_chk("R5 sum entry", msp, sum);
        if (msp > 1) peek_chk("R5 entry below kept", msp - 1, mdl[msp-1]);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i <= DEPTH; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        chk("R1 sp in reset", 32'(sp_o), 0);
        chk("R1 busy in reset", 32'(busy_o), 0);
        chk("R1 done in reset", 32'(done_o), 0);
        chk("R1 underflow in reset", 32'(underflow_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: empty and single-entry stacks refuse the add.
        for (int k = 0; k < 2; k++) begin
            if (k == 1) do_push(32'h0000_0011);
            start_i = 1'b1;
            opcode_i = OP_ADD;
            @(negedge clk);
            start_i = 1'b0;
            chk("R6 underflow pulse", 32'(underflow_o), 1);
            chk("R6 no busy", 32'(busy_o), 0);
            chk("R6 sp unchanged", 32'(sp_o), 32'(msp));
            @(negedge clk);
            chk("R6 underflow one cycle", 32'(underflow_o), 0);
        end

        // Vector table: push two operands, add, check sum and pointer.
        for (int v = 0; v < NVEC; v++) begin
            do_push(VEC[v][95:64]);
            do_push(VEC[v][63:32]);
            run_add(1'b0, 1'b0);
            peek_chk("R5 table sum", msp, VEC[v][31:0]);
        end

        // R7: other opcode ignored.
        start_i = 1'b1;
        opcode_i = 8'h61;
        @(negedge clk);
        start_i = 1'b0;
        chk("R7 no busy", 32'(busy_o), 0);
        chk("R7 no underflow", 32'(underflow_o), 0);
        repeat (3) @(negedge clk);
        chk("R7 sp unchanged", 32'(sp_o), 32'(msp));
        chk("R7 no done", 32'(done_o), 0);

        // R10: start and push in the same cycle; push dropped.
        run_add(1'b0, 1'b1);
        chk("R10 push dropped sp", 32'(sp_o), 32'(msp));
        peek_chk("R10 slot above untouched", msp + 1, mdl[msp+1]);

        // R8: start and push during busy ignored.
        run_add(1'b1, 1'b0);
        chk("R8 ignored while busy sp", 32'(sp_o), 32'(msp));
        peek_chk("R8 slot above untouched", msp + 1, mdl[msp+1]);
        @(negedge clk);
        chk("R8 no second add", 32'(busy_o), 0);

        // R3: fill to DEPTH, then push on a full stack.
        for (int k = 0; msp < DEPTH; k++) do_push(32'hA000_0000 + 32'(k));
        do_push(32'hDEAD_BEEF);
        chk("R3 full push sp", 32'(sp_o), 32'(DEPTH));
        peek_chk("R3 top unchanged", DEPTH, mdl[DEPTH]);
        run_add(1'b0, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule